// File: doc/BRIEF.md
# GPIO Port with Per-Pin Interrupt Triggers

This block is a 32-pin general-purpose I/O port controlled through a simple synchronous register bus. Software drives the pins through an output-value register and a per-pin output-enable register. It reads the pin levels, after synchronization, from a read-only pad register. A read of the output-value register returns the value written to it, whatever level the pin carries.

Every pin has its own interrupt trigger detector. The trigger kind is a 2-bit field, and the fields are packed into two configuration words: pins 0 to 15 use the low word and pins 16 to 31 use the high word. A separate dual-edge word overrides the field for any pin whose bit is set. Detected events set bits in a pending word, which software clears by writing ones. A mask word selects which pending bits raise an interrupt request. Requests from the lower and upper halves of the port can go to two separate request lines, or all of them can be merged onto one line.

Top module: `gpio_irq_port`

## Requirements
- R1: While reset is low, every register reads 0, `padOut` and `padOe` are 0, and both request lines are 0.
- R2: A write to word 0 (byte offset 0x00) updates `padOut` at the next clock edge. A read of word 0 returns the last value written, not the pin level.
- R3: A write to word 1 (offset 0x04) sets `padOe` at the next edge. A read of word 1 returns the same value.
- R4: Word 2 (offset 0x08) returns `padIn` after a two-flop synchronizer: a pin change made before edge k is visible after edge k+1. Writes to word 2 have no effect.
- R5: Pin p takes its trigger kind from bits [2*(p mod 16)+1 : 2*(p mod 16)] of word 3 (offset 0x0C) when p < 16, or of word 4 (offset 0x10) otherwise. The encoding is 0 = low level, 1 = high level, 2 = rising edge, 3 = falling edge. An edge is the synchronized value against its value one cycle earlier. For a pin change made before edge k, the pending bit is set after edge k+2.
- R6: A 1 in bit p of word 7 (offset 0x1C) makes pin p trigger on both edges, whatever its 2-bit field holds.
- R7: A write to the pending word 6 (offset 0x18) clears each bit written as 1 and leaves each bit written as 0 unchanged. Writing all ones clears every pending bit.
- R8: For a level trigger, the pending bit is set again on every cycle the level holds, so it stays set after a clear until the level goes away.
- R9: When a trigger event and a software clear hit the same pending bit in the same cycle, the bit ends up set.
- R10: Mask word 5 (offset 0x14) enables a pin with a 1. With split requests, `irqLo` is the OR of (pending AND mask) over pins 0 to 15 and `irqHi` is the same over pins 16 to 31. With a single request, `irqLo` covers all pins and `irqHi` is 0.
- R11: Address bits [1:0] are ignored. A register is written only when `busSel` and `busWr` are both 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Bus access select |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | 5 | Byte address; bits [4:2] select the word |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, combinational from the address |
| padIn | input | 32 | Asynchronous pin levels |
| padOut | output | 32 | Output values to the pins |
| padOe | output | 32 | Per-pin output enable |
| irqLo | output | 1 | Request for pins 0 to 15, or for all pins when the requests are merged |
| irqHi | output | 1 | Request for pins 16 to 31 |

## Verification
The bench drives the pins with several kinds of pattern. Single isolated rising and falling transitions pin down the two-cycle detect latency and the edge direction. A held high level and a held low level show the difference between level and edge triggers, including a bit that re-sets right after a clear. A pin with the dual-edge bit set sees both transitions, which shows the override of its field. A pin in the upper half tells the two request lines apart. A long phase of random pin toggles and random register writes, checked against a behavioural model on every clock, covers mixed configurations and clears that land on the same cycle as events.

// File: rtl/gpx_pkg.sv
package gpx_pkg;
  localparam int ADDR_W = 5;

  typedef enum logic [2:0] {
    WORD_DATA   = 3'd0,
    WORD_DIR    = 3'd1,
    WORD_PAD    = 3'd2,
    WORD_CFG_LO = 3'd3,
    WORD_CFG_HI = 3'd4,
    WORD_MASK   = 3'd5,
    WORD_STAT   = 3'd6,
    WORD_BOTH   = 3'd7
  } wordSel_e;

  typedef enum logic [1:0] {
    TRIG_LOW  = 2'd0,
    TRIG_HIGH = 2'd1,
    TRIG_RISE = 2'd2,
    TRIG_FALL = 2'd3
  } trig_e;

  typedef struct packed {
    logic     wrData;
    logic     wrDir;
    logic     wrCfgLo;
    logic     wrCfgHi;
    logic     wrMask;
    logic     wrClear;
    logic     wrBoth;
    wordSel_e rdSel;
  } ctrlStrobe_t;
endpackage

// File: rtl/gpx_ctrl.sv
module gpx_ctrl
  import gpx_pkg::*;
(
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  output ctrlStrobe_t       strobe
);
  wordSel_e wordIdx;
  logic     wrHit;

  // the two low address bits play no part in the decode
  assign wordIdx = wordSel_e'(busAddr[ADDR_W-1:2]);
  assign wrHit   = busSel && busWr;

  always_comb begin
    strobe         = '0;
    strobe.rdSel   = wordIdx;
    strobe.wrData  = wrHit && (wordIdx == WORD_DATA);
    strobe.wrDir   = wrHit && (wordIdx == WORD_DIR);
    strobe.wrCfgLo = wrHit && (wordIdx == WORD_CFG_LO);
    strobe.wrCfgHi = wrHit && (wordIdx == WORD_CFG_HI);
    strobe.wrMask  = wrHit && (wordIdx == WORD_MASK);
    strobe.wrClear = wrHit && (wordIdx == WORD_STAT);
    strobe.wrBoth  = wrHit && (wordIdx == WORD_BOTH);
  end
endmodule

// File: rtl/gpx_datapath.sv
module gpx_datapath
  import gpx_pkg::*;
#(
  parameter int PINS        = 32,
  parameter int SYNC_STAGES = 2,
  parameter bit SPLIT_IRQ   = 1'b1
) (
  input  logic            clk,
  input  logic            rstN,
  input  ctrlStrobe_t     strobe,
  input  logic [PINS-1:0] wdata,
  input  logic [PINS-1:0] padIn,
  output logic [PINS-1:0] rdata,
  output logic [PINS-1:0] padOut,
  output logic [PINS-1:0] padOe,
  output logic            irqLo,
  output logic            irqHi
);
  localparam int HALF = PINS / 2;

  logic [PINS-1:0] dataQ, dirQ, cfgLoQ, cfgHiQ, maskQ, statusQ, bothQ;
  logic [PINS-1:0] syncQ [SYNC_STAGES];
  logic [PINS-1:0] prevQ;
  logic [PINS-1:0] syncCur;
  logic [PINS-1:0] setVec;
  logic [PINS-1:0] clrVec;
  logic [PINS-1:0] pendVec;

  assign syncCur = syncQ[SYNC_STAGES-1];

  // input synchronizer and one-cycle history for edge detection
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < SYNC_STAGES; s++) syncQ[s] <= '0;
      prevQ <= '0;
    end else begin
      syncQ[0] <= padIn;
      for (int s = 1; s < SYNC_STAGES; s++) syncQ[s] <= syncQ[s-1];
      prevQ <= syncCur;
    end
  end

  // software-visible registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataQ  <= '0;
      dirQ   <= '0;
      cfgLoQ <= '0;
      cfgHiQ <= '0;
      maskQ  <= '0;
      bothQ  <= '0;
    end else begin
      if (strobe.wrData)  dataQ  <= wdata;
      if (strobe.wrDir)   dirQ   <= wdata;
      if (strobe.wrCfgLo) cfgLoQ <= wdata;
      if (strobe.wrCfgHi) cfgHiQ <= wdata;
      if (strobe.wrMask)  maskQ  <= wdata;
      if (strobe.wrBoth)  bothQ  <= wdata;
    end
  end

  // per-pin trigger detection
  for (genvar p = 0; p < PINS; p++) begin : gPin
    localparam int FIELD = 2 * (p % HALF);
    trig_e pinKind;
    if (p < HALF) begin : gLoField
      assign pinKind = trig_e'(cfgLoQ[FIELD +: 2]);
    end else begin : gHiField
      assign pinKind = trig_e'(cfgHiQ[FIELD +: 2]);
    end

    always_comb begin
      if (bothQ[p]) begin
        setVec[p] = syncCur[p] ^ prevQ[p];
      end else begin
        unique case (pinKind)
          TRIG_LOW:  setVec[p] = !syncCur[p];
          TRIG_HIGH: setVec[p] = syncCur[p];
          TRIG_RISE: setVec[p] = syncCur[p] && !prevQ[p];
          TRIG_FALL: setVec[p] = !syncCur[p] && prevQ[p];
          default:   setVec[p] = 1'b0;
        endcase
      end
    end
  end

  // pending bits: write-one-to-clear, a same-cycle event wins
  assign clrVec = strobe.wrClear ? wdata : '0;

  always_ff @(posedge clk) begin
    if (!rstN) statusQ <= '0;
    else       statusQ <= (statusQ & ~clrVec) | setVec;
  end

  assign pendVec = statusQ & maskQ;

  if (SPLIT_IRQ) begin : gSplitIrq
    assign irqLo = |pendVec[HALF-1:0];
    assign irqHi = |pendVec[PINS-1:HALF];
  end else begin : gMergedIrq
    assign irqLo = |pendVec;
    assign irqHi = 1'b0;
  end

  always_comb begin
    unique case (strobe.rdSel)
      WORD_DATA:   rdata = dataQ;
      WORD_DIR:    rdata = dirQ;
      WORD_PAD:    rdata = syncCur;
      WORD_CFG_LO: rdata = cfgLoQ;
      WORD_CFG_HI: rdata = cfgHiQ;
      WORD_MASK:   rdata = maskQ;
      WORD_STAT:   rdata = statusQ;
      WORD_BOTH:   rdata = bothQ;
      default:     rdata = '0;
    endcase
  end

  assign padOut = dataQ;
  assign padOe  = dirQ;

  // checks beside the logic they guard
  AST_DATA_READBACK: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrData |=> padOut == $past(wdata)); // R2
  AST_DIR_READBACK: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrDir |=> padOe == $past(wdata)); // R3
  AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (statusQ & ~$past(statusQ) & ~$past(setVec)) == '0); // R5
  AST_DUAL_EDGE: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ($past(bothQ & (syncCur ^ prevQ)) & ~statusQ) == '0); // R6
  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrClear |=> (statusQ & $past(wdata) & ~$past(setVec)) == '0); // R7
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ($past(setVec) & ~statusQ) == '0); // R9
  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqLo) |-> ($past(|setVec) || $past(strobe.wrMask))); // R10
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
  import gpx_pkg::*;
#(
  parameter int PINS        = 32,
  parameter int SYNC_STAGES = 2,
  parameter bit SPLIT_IRQ   = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [PINS-1:0]   busWdata,
  output logic [PINS-1:0]   busRdata,
  input  logic [PINS-1:0]   padIn,
  output logic [PINS-1:0]   padOut,
  output logic [PINS-1:0]   padOe,
  output logic              irqLo,
  output logic              irqHi
);
  ctrlStrobe_t strobe;

  gpx_ctrl ctrl_i (
    .busSel (busSel),
    .busWr  (busWr),
    .busAddr(busAddr),
    .strobe (strobe)
  );

  gpx_datapath #(
    .PINS       (PINS),
    .SYNC_STAGES(SYNC_STAGES),
    .SPLIT_IRQ  (SPLIT_IRQ)
  ) dp_i (
    .clk   (clk),
    .rstN  (rstN),
    .strobe(strobe),
    .wdata (busWdata),
    .padIn (padIn),
    .rdata (busRdata),
    .padOut(padOut),
    .padOe (padOe),
    .irqLo (irqLo),
    .irqHi (irqHi)
  );

  AST_WRITE_NEEDS_SEL: assert property (@(posedge clk) disable iff (!rstN)
    !(busSel && busWr) |=> $stable(padOut) && $stable(padOe)); // R11
endmodule

// File: tb/gpio_irq_port_tb_top.sv
module gpio_irq_port_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 1'b0;
  logic        busWr = 1'b0;
  logic [4:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [31:0] padIn = '0;
  logic [31:0] padOut, padOe;
  logic        irqLo, irqHi;

  int nChecks = 0;
  int nFails  = 0;

  always #2.5 clk = ~clk;

  gpio_irq_port dut_i (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .padIn(padIn), .padOut(padOut), .padOe(padOe),
    .irqLo(irqLo), .irqHi(irqHi)
  );

  // behavioural reference model
  logic [31:0] mData, mDir, mCfgLo, mCfgHi, mMask, mStat, mBoth;
  logic [31:0] mS1, mS2, mPrev;

  always @(posedge clk) begin
    if (!rstN) begin
      mData = 0; mDir = 0; mCfgLo = 0; mCfgHi = 0; mMask = 0;
      mStat = 0; mBoth = 0; mS1 = 0; mS2 = 0; mPrev = 0;
    end else begin
      logic [31:0] hits, clr;
      int word;
      hits = 0;
      for (int p = 0; p < 32; p++) begin
        int kind;
        bit cur, old;
        cur = mS2[p];
        old = mPrev[p];
        kind = (p < 16) ? ((mCfgLo >> (2 * p)) & 3) : ((mCfgHi >> (2 * (p - 16))) & 3);
        if (mBoth[p]) hits[p] = (cur != old);
        else case (kind)
          0: hits[p] = !cur;
          1: hits[p] = cur;
          2: hits[p] = cur && !old;
          default: hits[p] = !cur && old;
        endcase
      end
      word = busAddr / 4;
      clr = (busSel && busWr && word == 6) ? busWdata : 0;
      mStat = (mStat & ~clr) | hits;
      if (busSel && busWr) begin
        case (word)
          0: mData = busWdata;
          1: mDir = busWdata;
          3: mCfgLo = busWdata;
          4: mCfgHi = busWdata;
          5: mMask = busWdata;
          7: mBoth = busWdata;
          default: ;
        endcase
      end
      mPrev = mS2; mS2 = mS1; mS1 = padIn;
    end
  end

  function automatic logic [31:0] modelRead(int word);
    case (word)
      0: return mData;
      1: return mDir;
      2: return mS2;
      3: return mCfgLo;
      4: return mCfgHi;
      5: return mMask;
      6: return mStat;
      default: return mBoth;
    endcase
  endfunction

  function automatic string wordTag(int word);
    case (word)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      3, 4: return "R5";
      5: return "R10";
      6: return "R7";
      default: return "R6";
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // compare against the model on every clock, away from both edges
  always @(posedge clk) begin
    #2;
    check(padOut == mData, "R2 padOut", padOut, mData);
    check(padOe == mDir, "R3 padOe", padOe, mDir);
    check(irqLo == |(mStat[15:0] & mMask[15:0]), "R10 irqLo", {31'd0, irqLo},
          {31'd0, |(mStat[15:0] & mMask[15:0])});
    check(irqHi == |(mStat[31:16] & mMask[31:16]), "R10 irqHi", {31'd0, irqHi},
          {31'd0, |(mStat[31:16] & mMask[31:16])});
    check(busRdata == modelRead(busAddr / 4), wordTag(busAddr / 4), busRdata,
          modelRead(busAddr / 4));
  end

  task automatic busWrite(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b0;
  endtask

  // called at a negedge; samples the combinational read data
  task automatic busRead(input logic [4:0] a, output logic [31:0] d);
    busSel = 1'b1; busWr = 1'b0; busAddr = a;
    #1 d = busRdata;
  endtask

  task automatic waitCycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finishRun;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  endtask

  initial begin
    #(100000 * 5);
    nChecks++;
    nFails++;
    $display("FAIL watchdog actual=running expected=done");
    finishRun();
  end

  initial begin
    logic [31:0] rd;
    // R1: reset state
    waitCycles(3);
    for (int w = 0; w < 8; w++) begin
      busRead(5'(w * 4), rd);
      check(rd == 0, "R1 reset word", rd, 0);
    end
    check(padOut == 0 && padOe == 0, "R1 reset pads", padOut | padOe, 0);
    check(!irqLo && !irqHi, "R1 reset irq", {30'd0, irqHi, irqLo}, 0);
    @(negedge clk) rstN = 1'b1;

    // all pins rising-edge, clear the low-level pending from reset
    busWrite(5'h0C, 32'hAAAA_AAAA);
    busWrite(5'h10, 32'hAAAA_AAAA);
    busWrite(5'h18, 32'hFFFF_FFFF);
    busWrite(5'h14, 32'h0010_0008);
    busRead(5'h18, rd);
    check(rd == 0, "R7 clear all", rd, 0);

    // R5: rising edge on pin 3 and its latency
    busSel = 1'b0; busAddr = 5'h18;
    @(negedge clk) padIn[3] = 1'b1;
    waitCycles(2);
    #1 check(busRdata[3] == 1'b0, "R5 not yet set", busRdata, 0);
    @(negedge clk);
    #1 check(busRdata == 32'h8, "R5 rise set", busRdata, 32'h8);
    check(irqLo && !irqHi, "R10 low line", {30'd0, irqHi, irqLo}, 32'h1);

    // R7: zero write no effect, one write clears
    busWrite(5'h18, 32'h0);
    busRead(5'h18, rd);
    check(rd == 32'h8, "R7 zero write", rd, 32'h8);
    busWrite(5'h18, 32'h8);
    busRead(5'h18, rd);
    check(rd == 32'h0, "R7 one clears", rd, 0);

    // R10: upper pin goes to the second line
    @(negedge clk) padIn[20] = 1'b1;
    waitCycles(4);
    check(irqHi && !irqLo, "R10 high line", {30'd0, irqHi, irqLo}, 32'h2);
    busWrite(5'h18, 32'hFFFF_FFFF);

    // R5: falling trigger on pin 3 (field 3)
    busWrite(5'h0C, 32'hAAAA_AAEA);
    @(negedge clk) padIn[3] = 1'b0;
    waitCycles(4);
    busRead(5'h18, rd);
    check(rd == 32'h8, "R5 fall set", rd, 32'h8);
    busWrite(5'h18, 32'hFFFF_FFFF);

    // R6: both edges on pin 5, field says rising
    busWrite(5'h1C, 32'h20);
    @(negedge clk) padIn[5] = 1'b1;
    waitCycles(4);
    busRead(5'h18, rd);
    check(rd == 32'h20, "R6 rise", rd, 32'h20);
    busWrite(5'h18, 32'h20);
    @(negedge clk) padIn[5] = 1'b0;
    waitCycles(4);
    busRead(5'h18, rd);
    check(rd == 32'h20, "R6 fall", rd, 32'h20);
    busWrite(5'h18, 32'h20);

    // R8 / R9: high level on pin 7 (field 1)
    busWrite(5'h0C, 32'hAAAA_6AEA);
    @(negedge clk) padIn[7] = 1'b1;
    waitCycles(4);
    busRead(5'h18, rd);
    check(rd == 32'h80, "R8 level set", rd, 32'h80);
    busWrite(5'h18, 32'h80);
    busRead(5'h18, rd);
    check(rd == 32'h80, "R9 set beats clear", rd, 32'h80);
    waitCycles(5);
    busRead(5'h18, rd);
    check(rd == 32'h80, "R8 level holds", rd, 32'h80);
    @(negedge clk) padIn[7] = 1'b0;
    waitCycles(4);
    busWrite(5'h18, 32'h80);
    busRead(5'h18, rd);
    check(rd == 32'h0, "R8 level gone", rd, 0);

    // R5: low level on pin 16 (field 0 of the high word)
    busWrite(5'h10, 32'hAAAA_AAA8);
    waitCycles(2);
    busRead(5'h18, rd);
    check(rd == 32'h1_0000, "R5 low level", rd, 32'h1_0000);
    busWrite(5'h10, 32'hAAAA_AAAA);
    busWrite(5'h18, 32'hFFFF_FFFF);

    // R2 / R3 / R4 / R11
    busWrite(5'h00, 32'h1234_5678);
    busRead(5'h00, rd);
    check(rd == 32'h1234_5678, "R2 readback", rd, 32'h1234_5678);
    busRead(5'h03, rd);
    check(rd == 32'h1234_5678, "R11 low bits", rd, 32'h1234_5678);
    busWrite(5'h04, 32'hF0F0_F0F0);
    check(padOe == 32'hF0F0_F0F0, "R3 oe", padOe, 32'hF0F0_F0F0);
    busWrite(5'h08, 32'hFFFF_FFFF);
    busRead(5'h08, rd);
    check(rd == 32'h0010_0000, "R4 write ignored", rd, 32'h0010_0000);
    busSel = 1'b0; busAddr = 5'h08;
    @(negedge clk) padIn[9] = 1'b1;
    @(negedge clk);
    #1 check(busRdata == 32'h0010_0000, "R4 one stage", busRdata, 32'h0010_0000);
    @(negedge clk);
    #1 check(busRdata == 32'h0010_0200, "R4 two stages", busRdata, 32'h0010_0200);
    @(negedge clk) begin busSel = 1'b0; busWr = 1'b1; busAddr = 5'h00; busWdata = 32'h0; end
    @(negedge clk) busWr = 1'b0;
    check(padOut == 32'h1234_5678, "R11 no select", padOut, 32'h1234_5678);

    // random phase, checked by the model
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      busSel   = ($urandom % 4) != 0;
      busWr    = ($urandom % 3) == 0;
      busAddr  = 5'($urandom);
      busWdata = $urandom;
      if (($urandom % 4) == 0) padIn = padIn ^ (32'h1 << ($urandom % 32));
    end
    @(negedge clk) busSel = 1'b0;
    waitCycles(2);
    finishRun();
  end
endmodule